// File: doc/BRIEF.md
# Blanked Dual-Output Pulse-Width Modulator

This block generates a fixed-frequency pulse-width modulated drive on two outputs from a free-running digital sawtooth. Each period is `DEAD_CYC + RAMP_CYC` clock cycles long. It opens with a dead-time phase, during which both outputs are held low. A ramp phase follows. A pulse begins in the first ramp cycle. It ends at whichever comes first of three events:

- the ramp position reaching the duty command,
- a current-limit flag,
- an overcurrent flag.

A programmable leading-edge window suppresses the duty compare and the current-limit flag for the first cycles of every pulse. The overcurrent flag is never suppressed.

A mode pin selects how the two outputs share the pulses. In in-phase mode both outputs carry the same pulse. In alternating mode, successive periods are steered to A and then to B, so each output runs at half the period rate and stays below 50 % duty.

The analog comparators that surround such a modulator live outside this block. Their results arrive as synchronous one-bit flags. An external enable, normally driven by fault or undervoltage supervision, forces both outputs low. The interface carries no data stream, so every pin is a plain control or status level.

Top module: `pwm_blank_gen`

## Requirements
- R1: After reset the counter starts at period position 0. `dead_phase` is high for the first `DEAD_CYC` cycles of each period and low for the following `RAMP_CYC` cycles, and both outputs are low whenever `dead_phase` is high.
- R2: When enabled with a nonzero duty `D` and `blank_len` 0, the active outputs are high from ramp position 0 for `min(D, RAMP_CYC)` consecutive cycles.
- R3: A duty command of 0, sampled at the last dead cycle, produces no pulse in that period, whatever the blanking length.
- R4: The duty compare is ignored inside the blanking window, so a nonzero duty gives a pulse of `max(min(D,RAMP_CYC), min(blank_len,RAMP_CYC))` cycles.
- R5: A current-limit flag present during ramp position `r`, with `r >= blank_len`, drives the outputs low from position `r+1`. A flag present at `r < blank_len` has no effect.
- R6: An overcurrent flag present during ramp position `r` drives the outputs low from position `r+1`, even inside the blanking window. A flag present at the last dead cycle suppresses that period's pulse.
- R7: Once a pulse has ended within a period, the outputs stay low until the next period's ramp starts, even after the terminating flag drops.
- R8: With `alt_mode` = 0, `out_a` and `out_b` are identical in every cycle.
- R9: With `alt_mode` = 1, the steering alternates at every ramp start while enabled, beginning with A, and advances even in a period whose duty is 0. Only the selected output pulses.
- R10: When `enable` is sampled low, both outputs are low from the next cycle. The steering then returns to A, so A fires first after re-enable.
- R11: While `rst_n` is low, `out_a` and `out_b` are low and `dead_phase` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free, active-low synchronous reset |
| enable | input | 1 | High permits pulses; low forces both outputs low and resets steering |
| alt_mode | input | 1 | 0 = in-phase outputs, 1 = alternating outputs |
| duty | input | $clog2(RAMP_CYC+1) | Duty command in ramp cycles; 0 means no pulse |
| blank_len | input | $clog2(RAMP_CYC+1) | Leading-edge blanking length in ramp cycles |
| cur_lim | input | 1 | Synchronous current-limit flag (blankable) |
| over_cur | input | 1 | Synchronous overcurrent flag (never blanked) |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |
| dead_phase | output | 1 | High during the dead-time part of each period |

## Verification
The properties assume the following about the inputs:

- `enable`, `cur_lim` and `over_cur` are synchronous to `clk`.
- `duty`, `blank_len` and `alt_mode` are only meaningful at the last dead cycle, where the pulse is armed.

The stimulus respects this. It changes `duty`, `blank_len`, `alt_mode` and `enable` only in that last dead cycle. It asserts each flag for a single cycle at a chosen ramp position, and drops `enable` only mid-ramp. It never raises `over_cur` at the arming boundary. The expected waveform of every period is therefore a closed-form function of those few numbers.

// File: rtl/pwm_blank_pkg.sv
package pwm_blank_pkg;
  typedef enum logic {
    STEER_A = 1'b0,
    STEER_B = 1'b1
  } steer_e;

  function automatic steer_e steer_flip(input steer_e s);
    return (s == STEER_A) ? STEER_B : STEER_A;
  endfunction
endpackage

// File: rtl/pwm_ramp_timer.sv
module pwm_ramp_timer #(
  parameter int RAMP_CYC = 16,
  parameter int DEAD_CYC = 3,
  localparam int TOTAL = RAMP_CYC + DEAD_CYC,
  localparam int CW = $clog2(TOTAL),
  localparam int PW = $clog2(RAMP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          dead_now,
  output logic          start_nxt,
  output logic          last_ramp,
  output logic [PW-1:0] pos_now,
  output logic [PW-1:0] pos_nxt
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(TOTAL - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // Ramp position relative to the first ramp cycle.
  always_comb begin
    off       = cnt_q - CW'(DEAD_CYC);
    dead_now  = cnt_q < CW'(DEAD_CYC);
    start_nxt = cnt_q == CW'(DEAD_CYC - 1);
    last_ramp = cnt_q == CW'(TOTAL - 1);
    pos_now   = PW'(off);
    pos_nxt   = PW'(off + CW'(1));
  end
endmodule

// File: rtl/pwm_term_logic.sv
module pwm_term_logic #(
  parameter int RAMP_CYC = 16,
  localparam int PW = $clog2(RAMP_CYC + 1)
) (
  input  logic [PW-1:0] pos_now,
  input  logic [PW-1:0] pos_nxt,
  input  logic [PW-1:0] duty,
  input  logic [PW-1:0] blank_len,
  input  logic          cur_lim,
  input  logic          over_cur,
  output logic          stop_req
);
  logic flag_masked;
  logic cmp_masked;
  logic cmp_hit;

  always_comb begin
    // Flags seen in the current cycle are masked while inside the window.
    flag_masked = pos_now < blank_len;
    // The compare decides the next cycle, so it is masked by that position.
    cmp_masked  = pos_nxt < blank_len;
    cmp_hit     = pos_nxt >= duty;
    stop_req    = over_cur
                | (cur_lim & ~flag_masked)
                | (cmp_hit & ~cmp_masked);
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_blank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic alt_mode,
  input  logic start_nxt,
  input  logic last_ramp,
  input  logic stop_req,
  input  logic duty_zero,
  input  logic over_cur,
  output logic out_a,
  output logic out_b
);
  steer_e next_q;
  logic   fire;
  logic   pick_a;
  logic   pick_b;

  always_comb begin
    fire   = ~duty_zero & ~over_cur;
    pick_a = ~alt_mode | (next_q == STEER_A);
    pick_b = ~alt_mode | (next_q == STEER_B);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      out_a  <= 1'b0;
      out_b  <= 1'b0;
      next_q <= STEER_A;
    end else if (start_nxt) begin
      out_a  <= fire & pick_a;
      out_b  <= fire & pick_b;
      next_q <= alt_mode ? steer_flip(next_q) : STEER_A;
    end else if (last_ramp || stop_req) begin
      out_a  <= 1'b0;
      out_b  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_blank_gen.sv
module pwm_blank_gen #(
  parameter int RAMP_CYC = 16,
  parameter int DEAD_CYC = 3,
  localparam int PW = $clog2(RAMP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          alt_mode,
  input  logic [PW-1:0] duty,
  input  logic [PW-1:0] blank_len,
  input  logic          cur_lim,
  input  logic          over_cur,
  output logic          out_a,
  output logic          out_b,
  output logic          dead_phase
);
  logic          start_nxt;
  logic          last_ramp;
  logic          stop_req;
  logic [PW-1:0] pos_now;
  logic [PW-1:0] pos_nxt;

  pwm_ramp_timer #(.RAMP_CYC(RAMP_CYC), .DEAD_CYC(DEAD_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .dead_now  (dead_phase),
    .start_nxt (start_nxt),
    .last_ramp (last_ramp),
    .pos_now   (pos_now),
    .pos_nxt   (pos_nxt)
  );

  pwm_term_logic #(.RAMP_CYC(RAMP_CYC)) u_term (
    .pos_now   (pos_now),
    .pos_nxt   (pos_nxt),
    .duty      (duty),
    .blank_len (blank_len),
    .cur_lim   (cur_lim),
    .over_cur  (over_cur),
    .stop_req  (stop_req)
  );

  pwm_steer u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .alt_mode  (alt_mode),
    .start_nxt (start_nxt),
    .last_ramp (last_ramp),
    .stop_req  (stop_req),
    .duty_zero (duty == '0),
    .over_cur  (over_cur),
    .out_a     (out_a),
    .out_b     (out_b)
  );
endmodule

// File: rtl/pwm_blank_gen_chk.sv
module pwm_blank_gen_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [PW-1:0] duty,
  input logic          over_cur,
  input logic          out_a,
  input logic          out_b,
  input logic          dead_phase
);
  // R1
  dead_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dead_phase |-> (!out_a && !out_b));

  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) || $rose(out_b)) |-> $fell(dead_phase));

  // R3
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dead_phase) && ($past(duty) == '0)) |-> (!out_a && !out_b));

  // R6
  over_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_cur |=> (!out_a && !out_b));

  // R7
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead_phase && !out_a) |=> !out_a);

  // R7
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dead_phase && !out_b) |=> !out_b);

  // R10
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_a && !out_b));
endmodule

bind pwm_blank_gen pwm_blank_gen_chk #(.PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .duty       (duty),
  .over_cur   (over_cur),
  .out_a      (out_a),
  .out_b      (out_b),
  .dead_phase (dead_phase)
);

// File: tb/pwm_blank_gen_bench.sv
module pwm_blank_gen_bench;
  localparam int RAMP = 16;
  localparam int DEAD = 3;
  localparam int T    = RAMP + DEAD;
  localparam int PW   = $clog2(RAMP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          alt_mode = 1'b0;
  logic [PW-1:0] duty = '0;
  logic [PW-1:0] blank_len = '0;
  logic          cur_lim = 1'b0;
  logic          over_cur = 1'b0;
  logic          out_a;
  logic          out_b;
  logic          dead_phase;

  int    checks = 0;
  int    errors = 0;
  int    pos = 0;
  bit    steer_b = 1'b0;
  bit    done = 1'b0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  pwm_blank_gen #(.RAMP_CYC(RAMP), .DEAD_CYC(DEAD)) u_pwm_blank_gen (
    .clk (clk), .rst_n (rst_n), .enable (enable), .alt_mode (alt_mode),
    .duty (duty), .blank_len (blank_len), .cur_lim (cur_lim),
    .over_cur (over_cur), .out_a (out_a), .out_b (out_b),
    .dead_phase (dead_phase)
  );

  always #5 clk = ~clk;

  // Bench copy of the period position, counted from reset release.
  always @(posedge clk) begin
    if (!rst_n) pos <= 0;
    else pos <= (pos == T - 1) ? 0 : pos + 1;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: arms one period, pushes its expected waveform, plays flags.
  task automatic run_period(input int d, input int bl, input bit alt,
                            input bit en, input int cl_at, input int oc_at,
                            input int drop_at, input string tag);
    int w;
    bit sa;
    bit sb;
    do @(negedge clk); while (pos != DEAD - 1);
    duty = PW'(d); blank_len = PW'(bl); alt_mode = alt; enable = en;
    cur_lim = 1'b0; over_cur = 1'b0;
    if (!en || d == 0) w = 0;
    else begin
      w = (d < RAMP) ? d : RAMP;
      if (((bl < RAMP) ? bl : RAMP) > w) w = (bl < RAMP) ? bl : RAMP;
    end
    if (cl_at >= 0 && cl_at >= bl && cl_at + 1 < w) w = cl_at + 1;
    if (oc_at >= 0 && oc_at + 1 < w) w = oc_at + 1;
    if (drop_at >= 0 && drop_at + 1 < w) w = drop_at + 1;
    if (!en) begin sa = 0; sb = 0; steer_b = 0; end
    else if (alt) begin sa = !steer_b; sb = steer_b; steer_b = !steer_b; end
    else begin sa = 1; sb = 1; steer_b = 0; end
    if (drop_at >= 0) steer_b = 0;
    for (int r = 0; r < RAMP; r++) begin
      exp_q.push_back({(r < w) && sa, (r < w) && sb, 1'b0});
      tag_q.push_back(tag);
    end
    for (int k = 0; k < DEAD; k++) begin
      exp_q.push_back(3'b001);
      tag_q.push_back("R1");
    end
    for (int r = 0; r < RAMP; r++) begin
      @(negedge clk);
      cur_lim  = (r == cl_at);
      over_cur = (r == oc_at);
      if (r == drop_at) enable = 1'b0;
    end
    @(negedge clk);
    cur_lim = 1'b0; over_cur = 1'b0;
  endtask

  // Monitor: pops one expected cycle per clock and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_a, e[2], t);
        chk(out_b, e[1], t);
        chk(dead_phase, e[0], "R1");
      end
    end
  end

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_a, 1'b0, "R11");
    chk(out_b, 1'b0, "R11");
    chk(dead_phase, 1'b1, "R11");
    rst_n = 1'b1;
    run_period(5, 0, 0, 1, -1, -1, -1, "R2");
    run_period(0, 4, 0, 1, -1, -1, -1, "R3");
    run_period(20, 0, 0, 1, -1, -1, -1, "R2");
    run_period(3, 7, 0, 1, -1, -1, -1, "R4");
    run_period(10, 4, 0, 1, 2, -1, -1, "R5");
    run_period(10, 4, 0, 1, 6, -1, -1, "R5");
    run_period(12, 8, 0, 1, -1, 1, -1, "R6");
    run_period(9, 0, 0, 1, 3, -1, -1, "R7");
    run_period(4, 0, 0, 1, -1, -1, -1, "R8");
    run_period(6, 0, 1, 1, -1, -1, -1, "R9");
    run_period(6, 0, 1, 1, -1, -1, -1, "R9");
    run_period(0, 0, 1, 1, -1, -1, -1, "R9");
    run_period(6, 0, 1, 1, -1, -1, -1, "R9");
    run_period(6, 0, 1, 1, -1, -1, 3, "R10");
    run_period(6, 0, 1, 1, -1, -1, -1, "R10");
    run_period(8, 0, 0, 0, -1, -1, -1, "R10");
    run_period(7, 2, 1, 1, -1, 4, -1, "R6");
    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    finish_up();
  end
endmodule